// File: doc/BRIEF.md
# Half-Step Conversion Clock Divider

This block produces the timing base for an analog-to-digital conversion sequencer. It runs from a fast clock at twice the instruction rate and divides it by a 6-bit setting N. The resulting conversion period is N+1 fast cycles, which is (N+1)/2 instruction cycles. Because the step is half an instruction cycle, the period can be a whole or a half-odd number of instruction cycles. For example, N = 5 gives a period of three instruction cycles.

The block has two outputs for the sequencer. The first is a one-cycle tick at every period boundary. The second is a level that changes state after each tick. A registered select can replace the divided source with tick pulses from an internal oscillator; those pulses must already be synchronous to the fast clock. A flag output warns software when the divided period is shorter than a minimum number of fast cycles, set by a parameter. This guards the converter's minimum period. The divide setting N should be chosen as the smallest value that satisfies N >= 2·Tperiod/Tinstr − 1.

Top module: `tad_divider`

## Requirements
- R1: While reset is asserted, and after reset until enable is first sampled high, tad_tick and tad_level are low. tad_short is low while reset is asserted.
- R2: With the divided source selected, take the clock edge on which enable is first sampled high as edge k. tad_tick is high for one cycle after edge k+N, and again every N+1 cycles after that, where N is div_set.
- R3: The divider covers the full range of div_set. N = 0 ticks in every cycle, and N = 63 ticks once every 64 cycles.
- R4: A change of div_set during a period does not alter that period. The new value sets the length of the period that starts at the next tick.
- R5: After enable is sampled low, no tick appears from the next cycle on. A later enable restarts with a full period, as in R2.
- R6: While use_osc is high, it is registered on one edge, and tad_tick then follows osc_tick. An osc_tick sampled high on edge m gives a tick in the cycle after edge m, and the divided ticks are suppressed.
- R7: tad_level inverts on the edge that follows each tick, provided enable is still sampled high on that edge. It returns to 0 on the edge where enable is sampled low.
- R8: tad_short is high when the divided source is selected and N+1 is less than MIN_PERIOD (default 6). N here is the setting the counter is using. While disabled, that setting follows div_set with one edge of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk2x | input | 1 | Fast clock at twice the instruction rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the divider; low holds it idle and reloaded |
| div_set | input | 6 | Divide setting N; period is N+1 fast cycles |
| use_osc | input | 1 | Selects the oscillator tick source |
| osc_tick | input | 1 | Oscillator tick pulse, synchronous to clk2x |
| tad_tick | output | 1 | One-cycle period boundary tick |
| tad_level | output | 1 | Level that inverts after every tick |
| tad_short | output | 1 | Divided period is below MIN_PERIOD |

## Verification
A counter that holds a wrong value, or reloads from the wrong setting, moves a tick off its predicted cycle. The scoreboard reports the error at the first tick after the fault, which is at most N+1 cycles later. A fault in the source select or the run state produces a tick that the scoreboard does not expect, and this shows within one cycle. A fault in the level toggle shows on the edge after any tick. A fault in the comparison behind the short flag shows one edge after the setting changes.

// File: rtl/tad_pkg.sv
package tad_pkg;
  typedef enum logic {SRC_DIV = 1'b0, SRC_OSC = 1'b1} tad_src_e;
endpackage

// File: rtl/tad_rst_sync.sv
module tad_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/tad_down_counter.sv
module tad_down_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] div_in,
  output logic         run_o,
  output logic [W-1:0] cnt_o,
  output logic         zero_o,
  output logic [W-1:0] n_act_o
);
  logic         run_q, run_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] nact_q, nact_d;
  logic         zero;
  logic         reload;

  assign zero   = (cnt_q == '0);
  assign reload = !run_q || zero;

  // next state: idle keeps loading, running counts down and reloads at zero
  always_comb begin
    run_d  = enable;
    cnt_d  = cnt_q - 1'b1;
    nact_d = nact_q;
    if (reload) begin
      cnt_d  = div_in;
      nact_d = div_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      nact_q <= '1;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      nact_q <= nact_d;
    end
  end

  assign run_o   = run_q;
  assign cnt_o   = cnt_q;
  assign zero_o  = run_q && zero;
  assign n_act_o = nact_q;
endmodule

// File: rtl/tad_src_select.sv
module tad_src_select
  import tad_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     enable,
  input  logic     run,
  input  logic     use_osc,
  input  logic     osc_tick,
  input  logic     div_zero,
  output logic     tick_o,
  output logic     level_o,
  output tad_src_e src_o
);
  tad_src_e src_q, src_d;
  logic     osc_q, osc_d;
  logic     lvl_q, lvl_d;
  logic     tick;

  assign tick = run && ((src_q == SRC_OSC) ? osc_q : div_zero);

  always_comb begin
    src_d = use_osc ? SRC_OSC : SRC_DIV;
    osc_d = osc_tick;
    lvl_d = lvl_q;
    if (!enable)   lvl_d = 1'b0;
    else if (tick) lvl_d = !lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_DIV;
      osc_q <= 1'b0;
      lvl_q <= 1'b0;
    end else begin
      src_q <= src_d;
      osc_q <= osc_d;
      lvl_q <= lvl_d;
    end
  end

  assign tick_o  = tick;
  assign level_o = lvl_q;
  assign src_o   = src_q;
endmodule

// File: rtl/tad_divider.sv
module tad_divider
  import tad_pkg::*;
#(
  parameter int DIV_W      = 6,
  parameter int MIN_PERIOD = 6
) (
  input  logic             clk2x,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [DIV_W-1:0] div_set,
  input  logic             use_osc,
  input  logic             osc_tick,
  output logic             tad_tick,
  output logic             tad_level,
  output logic             tad_short
);
  localparam int PW = DIV_W + 1;
  localparam logic [PW-1:0] MIN_CYC = PW'(MIN_PERIOD);

  logic             rst_sync_n;
  logic             run_q;
  logic [DIV_W-1:0] cnt_q;
  logic             div_zero;
  logic [DIV_W-1:0] n_act;
  tad_src_e         src_q;
  logic [PW-1:0]    period_cyc;

  tad_rst_sync u_rst (
    .clk        (clk2x),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tad_down_counter #(.W(DIV_W)) u_cnt (
    .clk     (clk2x),
    .rst_n   (rst_sync_n),
    .enable  (enable),
    .div_in  (div_set),
    .run_o   (run_q),
    .cnt_o   (cnt_q),
    .zero_o  (div_zero),
    .n_act_o (n_act)
  );

  tad_src_select u_sel (
    .clk      (clk2x),
    .rst_n    (rst_sync_n),
    .enable   (enable),
    .run      (run_q),
    .use_osc  (use_osc),
    .osc_tick (osc_tick),
    .div_zero (div_zero),
    .tick_o   (tad_tick),
    .level_o  (tad_level),
    .src_o    (src_q)
  );

  assign period_cyc = {1'b0, n_act} + {{DIV_W{1'b0}}, 1'b1};
  assign tad_short  = (src_q == SRC_DIV) && (period_cyc < MIN_CYC);
endmodule

// File: rtl/tad_divider_chk.sv
module tad_divider_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [DIV_W-1:0] div_in,
  input logic             osc_tick,
  input logic             run,
  input logic [DIV_W-1:0] cnt,
  input logic             sel_osc,
  input logic             tick,
  input logic             level
);
  logic [DIV_W-1:0] gap_q;
  logic [DIV_W-1:0] hold_q;

  // independent period tracker: cycles since load versus the loaded setting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      hold_q <= '0;
    end else if (!run || cnt == '0) begin
      gap_q  <= '0;
      hold_q <= div_in;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  a_r2_period: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '0) |-> (gap_q == hold_q));

  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tick);

  a_r6_osc_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel_osc) |-> $past(osc_tick));

  a_r7_level_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && enable) |=> (level != $past(level)));

  a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && enable) |=> $stable(level));
endmodule

bind tad_divider tad_divider_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk2x),
  .rst_n    (rst_sync_n),
  .enable   (enable),
  .div_in   (div_set),
  .osc_tick (osc_tick),
  .run      (run_q),
  .cnt      (cnt_q),
  .sel_osc  (src_q == tad_pkg::SRC_OSC),
  .tick     (tad_tick),
  .level    (tad_level)
);

// File: tb/tad_divider_bench.sv
module tad_divider_bench;
  logic       clk2x = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [5:0] div_set;
  logic       use_osc;
  logic       osc_tick;
  logic       tad_tick;
  logic       tad_level;
  logic       tad_short;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int exp_q[$];
  bit done  = 1'b0;

  always #4 clk2x = !clk2x;
  always @(posedge clk2x) cyc <= cyc + 1;

  tad_divider u_tad_divider (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .enable    (enable),
    .div_set   (div_set),
    .use_osc   (use_osc),
    .osc_tick  (osc_tick),
    .tad_tick  (tad_tick),
    .tad_level (tad_level),
    .tad_short (tad_short)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // monitor: every tick must match the oldest expected cycle
  always @(negedge clk2x) begin
    if (rst_n && tad_tick) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected tick", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cyc == e, "R2 tick cycle", cyc, e);
      end
    end
  end

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk2x);
  endtask

  task automatic drain_check(input string req);
    repeat (3) @(negedge clk2x);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  // driver: divided run of count ticks with setting n
  task automatic run_div(input int n, input int count, input string req);
    int k;
    @(negedge clk2x);
    div_set = 6'(n); use_osc = 1'b0; enable = 1'b1;
    k = cyc + 1;
    for (int i = 0; i < count; i++) exp_q.push_back(k + n + i * (n + 1));
    wait_until(k + n + (count - 1) * (n + 1));
    enable = 1'b0;
    drain_check(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk2x);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k;
    rst_n = 1'b0; enable = 1'b0; div_set = 6'd5; use_osc = 1'b0; osc_tick = 1'b0;
    repeat (3) @(negedge clk2x);
    chk(!tad_tick,  "R1 tick in reset",  tad_tick,  0);
    chk(!tad_level, "R1 level in reset", tad_level, 0);
    chk(!tad_short, "R1 short in reset", tad_short, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk2x);
    chk(!tad_tick && !tad_level, "R1 idle after reset", {tad_tick, tad_level}, 0);

    run_div(5, 3, "R2 n5 drain");
    run_div(2, 4, "R2 n2 drain");
    run_div(0, 5, "R3 n0 drain");
    run_div(63, 2, "R3 n63 drain");

    // R5: idle with a fast setting, nothing may tick
    div_set = 6'd0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk2x);
      chk(!tad_tick, "R5 idle tick", tad_tick, 0);
    end
    run_div(3, 2, "R5 restart full period");

    // R4: change setting mid-period
    @(negedge clk2x);
    div_set = 6'd5; enable = 1'b1; k = cyc + 1;
    exp_q.push_back(k + 5); exp_q.push_back(k + 8); exp_q.push_back(k + 11);
    wait_until(k + 2);
    div_set = 6'd2;
    wait_until(k + 11);
    enable = 1'b0;
    drain_check("R4 drain");

    // R7: level toggling with N=1
    @(negedge clk2x);
    div_set = 6'd1; enable = 1'b1; k = cyc + 1;
    exp_q.push_back(k + 1); exp_q.push_back(k + 3); exp_q.push_back(k + 5);
    wait_until(k + 1);
    chk(!tad_level, "R7 level before first flip", tad_level, 0);
    wait_until(k + 2);
    chk(tad_level,  "R7 level after tick 1", tad_level, 1);
    wait_until(k + 3);
    chk(tad_level,  "R7 level held", tad_level, 1);
    wait_until(k + 4);
    chk(!tad_level, "R7 level after tick 2", tad_level, 0);
    wait_until(k + 5);
    enable = 1'b0;
    wait_until(k + 6);
    chk(!tad_level, "R7 level cleared on disable", tad_level, 0);
    drain_check("R7 drain");

    // R6: oscillator source, divided ticks (N=0) must be suppressed
    @(negedge clk2x);
    div_set = 6'd0; use_osc = 1'b1; enable = 1'b1; k = cyc;
    exp_q.push_back(k + 4); exp_q.push_back(k + 8);
    exp_q.push_back(k + 11); exp_q.push_back(k + 12);
    wait_until(k + 3);  osc_tick = 1'b1;
    wait_until(k + 4);  osc_tick = 1'b0;
    wait_until(k + 7);  osc_tick = 1'b1;
    wait_until(k + 8);  osc_tick = 1'b0;
    wait_until(k + 10); osc_tick = 1'b1;
    wait_until(k + 12); osc_tick = 1'b0;
    wait_until(k + 14);
    chk(!tad_short, "R8 short off with osc source", tad_short, 0);
    enable = 1'b0; use_osc = 1'b0;
    drain_check("R6 drain");

    // R8: short-period flag, MIN_PERIOD=6
    @(negedge clk2x); div_set = 6'd4;
    @(negedge clk2x); chk(tad_short,  "R8 n4 short", tad_short, 1);
    div_set = 6'd5;
    @(negedge clk2x); chk(!tad_short, "R8 n5 not short", tad_short, 0);
    div_set = 6'd0;
    @(negedge clk2x); chk(tad_short,  "R8 n0 short", tad_short, 1);
    use_osc = 1'b1;
    @(negedge clk2x); chk(!tad_short, "R8 osc masks flag", tad_short, 0);
    use_osc = 1'b0; div_set = 6'd63;
    @(negedge clk2x); chk(!tad_short, "R8 n63 not short", tad_short, 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule